// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Receiver

This block is the serial front end of a multi-channel converter controller. Everything runs on one fast system clock. The serial clock, serial data and active-low chip-select/load inputs are brought into that domain through two-flop synchronizers. Edges of the serial clock and of chip-select are found by comparing consecutive registered samples. Because of this, the system clock must run at least four times faster than the serial clock.

While chip-select is low, each rising serial-clock edge shifts one data bit into a 32-bit register. The bit that leaves the far end of that register is driven on the serial output after each falling edge, so several receivers can share one data chain and one load strobe. When chip-select returns high, the most recent 24 bits are presented as a 4-bit command, a 4-bit address and a 16-bit data field, together with a one-cycle execute pulse. Frames of 24 bits and of 32 bits are both accepted. An asynchronous active-low clear returns the receiver to its idle state.

Top module: `chain_cmd_rx`

## Requirements
- R1: A data bit is captured on a serial-clock rising edge only while chip-select/load is low. Serial-clock edges seen while chip-select/load is high change neither the stored bits nor the serial output.
- R2: After each falling serial-clock edge with chip-select/load low, the serial output carries the bit that was captured 32 rising edges earlier. The output is 0 while fewer than 32 bits have been captured since the last clear.
- R3: On a chip-select/load rising edge that ends a frame of at least 24 bits, the execute output is high for exactly one system-clock cycle. This pulse comes on the third system-clock rising edge after the edge is applied at the pin.
- R4: With the execute pulse, the outputs are loaded from the last 24 bits of the frame, taken in arrival order: command = bits 1 to 4 (the first bit is the MSB), address = bits 5 to 8 (MSB first), data = bits 9 to 24 (MSB first).
- R5: In a 32-bit frame, the first 8 bits are discarded and the trailing 24 bits form the word.
- R6: Frames longer than 32 bits keep shifting, and the last 24 bits still form the word.
- R7: A frame of fewer than 24 bits gives no execute pulse and leaves the command, address and data outputs unchanged.
- R8: Driving the clear input low immediately forces command, address, data, execute and serial output to 0. It also discards every bit captured so far.
- R9: The command, address and data outputs hold their values between execute pulses.
- R10: With two receivers chained (serial output to serial input) and sharing the clock, chip-select and clear, a 64-bit frame delivers its first 32-bit word to the far receiver and its second word to the near one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clrN | input | 1 | Asynchronous active-low clear |
| sckIn | input | 1 | Serial clock |
| sdiIn | input | 1 | Serial data in |
| csLdN | input | 1 | Active-low chip-select; its rising edge loads the word |
| sdoOut | output | 1 | Serial data out for chaining |
| cmdOut | output | 4 | Received command field |
| addrOut | output | 4 | Received address field |
| dataOut | output | 16 | Received data field |
| execOut | output | 1 | One-cycle execute strobe |

## Verification
The execute pulse and the new fields appear on the third system-clock rising edge after chip-select is raised. The bench therefore samples them at the falling edge that follows that third rising edge, and one cycle later it checks that the pulse has dropped. The serial output settles three system-clock edges after a serial-clock fall, and the bench compares it with an arithmetic bit history four cycles after each fall, which is well before the next rising edge. Clear is combinational at the outputs and is sampled one time unit after it is asserted. Every inert frame, such as a short frame or edges while deselected, is watched for six cycles to confirm that no pulse appears.

// File: rtl/chain_cmd_pkg.sv
package chain_cmd_pkg;
  // Strobes from the control to the datapath, valid for one system clock.
  typedef struct packed {
    logic shiftEn;   // capture one serial bit
    logic sdoUpd;    // present the oldest bit on the serial output
    logic latchCmd;  // copy the trailing word to the field registers
  } strobe_t;
endpackage

// File: rtl/chain_cmd_sync.sv
module chain_cmd_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/chain_cmd_ctrl.sv
module chain_cmd_ctrl
  import chain_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int WORD_BITS = 24
) (
  input  logic    clk,
  input  logic    clrN,
  input  logic    sckS,
  input  logic    csS,
  output strobe_t strobe,
  output logic    execOut
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] WORD_MIN = CNT_W'(WORD_BITS);

  logic sckD, csD, execQ;
  logic sckRise, sckFall, csRise;
  logic [CNT_W-1:0] bitCnt;

  assign sckRise = sckS & ~sckD;
  assign sckFall = ~sckS & sckD;
  assign csRise  = csS & ~csD;

  always_comb begin
    strobe.shiftEn  = sckRise & ~csS;
    strobe.sdoUpd   = sckFall & ~csS;
    strobe.latchCmd = csRise & (bitCnt >= WORD_MIN);
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      sckD  <= 1'b0;
      csD   <= 1'b1;
      execQ <= 1'b0;
    end else begin
      sckD  <= sckS;
      csD   <= csS;
      execQ <= strobe.latchCmd;
    end
  end

  // Saturating bit count of the current frame.
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                               bitCnt <= '0;
    else if (csS)                            bitCnt <= '0;
    else if (sckRise && bitCnt != CNT_MAX)   bitCnt <= bitCnt + 1'b1;
  end

  assign execOut = execQ;

  a_r3_exec_one_cycle: assert property (@(posedge clk) disable iff (!clrN)
    execQ |=> !execQ);
  a_r7_short_no_exec: assert property (@(posedge clk) disable iff (!clrN)
    (csRise && bitCnt < WORD_MIN) |=> !execQ);
  a_r1_cnt_idle: assert property (@(posedge clk) disable iff (!clrN)
    (csS && csD) |-> bitCnt == '0);
endmodule

// File: rtl/chain_cmd_dpath.sv
module chain_cmd_dpath
  import chain_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int CMD_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              sdiS,
  input  strobe_t           strobe,
  output logic              sdoOut,
  output logic [CMD_W-1:0]  cmdOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut
);
  localparam int ADDR_LSB = DATA_W;
  localparam int CMD_LSB = DATA_W + ADDR_W;

  logic [FRAME_BITS-1:0] shiftReg;
  logic                  sdoQ;
  logic [CMD_W-1:0]      cmdQ;
  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     dataQ;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[FRAME_BITS-2:0], sdiS};
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)              sdoQ <= 1'b0;
    else if (strobe.sdoUpd) sdoQ <= shiftReg[FRAME_BITS-1];
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      cmdQ  <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.latchCmd) begin
      cmdQ  <= shiftReg[CMD_LSB +: CMD_W];
      addrQ <= shiftReg[ADDR_LSB +: ADDR_W];
      dataQ <= shiftReg[0 +: DATA_W];
    end
  end

  assign sdoOut  = sdoQ;
  assign cmdOut  = cmdQ;
  assign addrOut = addrQ;
  assign dataOut = dataQ;

  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.shiftEn |=> $stable(shiftReg));
  a_r2_sdo_only_on_fall: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.sdoUpd |=> $stable(sdoQ));
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.latchCmd |=> ($stable(cmdQ) && $stable(addrQ) && $stable(dataQ)));
endmodule

// File: rtl/chain_cmd_rx.sv
module chain_cmd_rx
  import chain_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int CMD_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              sckIn,
  input  logic              sdiIn,
  input  logic              csLdN,
  output logic              sdoOut,
  output logic [CMD_W-1:0]  cmdOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              execOut
);
  localparam int WORD_BITS = CMD_W + ADDR_W + DATA_W;

  logic [2:0] pinSync;
  strobe_t    strobe;

  chain_cmd_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .clrN(clrN),
    .din({csLdN, sckIn, sdiIn}),
    .dout(pinSync)
  );

  chain_cmd_ctrl #(
    .FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS)
  ) u_ctrl (
    .clk(clk), .clrN(clrN),
    .sckS(pinSync[1]), .csS(pinSync[2]),
    .strobe(strobe), .execOut(execOut)
  );

  chain_cmd_dpath #(
    .FRAME_BITS(FRAME_BITS), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .clrN(clrN),
    .sdiS(pinSync[0]), .strobe(strobe),
    .sdoOut(sdoOut), .cmdOut(cmdOut), .addrOut(addrOut), .dataOut(dataOut)
  );

  a_r8_clear_quiet: assert property (@(posedge clk)
    !clrN |-> (!execOut && !sdoOut && cmdOut == '0));
endmodule

// File: tb/tb_chain_cmd_rx.sv
module tb_chain_cmd_rx;
  logic clk = 1'b0;
  logic clrN = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, csN = 1'b1;
  logic sdo, exec, sdo2, exec2;
  logic [3:0] cmd, addr, cmd2, addr2;
  logic [15:0] data, data2;

  int checks = 0, errors = 0;
  logic sentBits [0:2047];
  int sentCnt = 0;
  logic [3:0] eCmd = '0, eAddr = '0;
  logic [15:0] eData = '0;

  always #10 clk = ~clk;

  chain_cmd_rx dut (.clk(clk), .clrN(clrN), .sckIn(sck), .sdiIn(sdi), .csLdN(csN),
    .sdoOut(sdo), .cmdOut(cmd), .addrOut(addr), .dataOut(data), .execOut(exec));

  chain_cmd_rx dut2 (.clk(clk), .clrN(clrN), .sckIn(sck), .sdiIn(sdo), .csLdN(csN),
    .sdoOut(sdo2), .cmdOut(cmd2), .addrOut(addr2), .dataOut(data2), .execOut(exec2));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic expSdo();
    if (sentCnt >= 32) return sentBits[sentCnt-32];
    return 1'b0;
  endfunction

  // One serial clock period; the serial output is checked after the fall.
  task automatic sendBit(logic b);
    @(negedge clk) sdi = b;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    if (!csN) begin
      sentBits[sentCnt] = b;
      sentCnt = sentCnt + 1;
    end
    repeat (4) @(negedge clk);
    sck = 1'b0;
    repeat (4) @(negedge clk);
    chk(csN ? "R1" : "R2", "sdo", 32'(sdo), 32'(expSdo()));
  endtask

  task automatic sendBits(logic [63:0] w, int n);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  // Full frame: select, shift n bits of w, deselect, check the result.
  task automatic frame(logic [63:0] w, int n, string req);
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
    sendBits(w, n);
    @(negedge clk) csN = 1'b1;
    if (n >= 24) begin
      eCmd = w[23:20];
      eAddr = w[19:16];
      eData = w[15:0];
      repeat (3) @(negedge clk);
      chk(req, "exec pulse (R3)", 32'(exec), 32'd1);
      chk(req, "cmd (R4)", 32'(cmd), 32'(eCmd));
      chk(req, "addr (R4)", 32'(addr), 32'(eAddr));
      chk(req, "data (R4)", 32'(data), 32'(eData));
      @(negedge clk);
      chk("R3", "exec drops", 32'(exec), 32'd0);
      repeat (2) @(negedge clk);
    end else begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(req, "no exec", 32'(exec), 32'd0);
      end
      chk(req, "cmd held", 32'(cmd), 32'(eCmd));
      chk(req, "data held", 32'(data), 32'(eData));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "reset sdo", 32'(sdo), 32'd0);
    chk("R8", "reset exec", 32'(exec), 32'd0);
    chk("R8", "reset fields", {cmd, addr, data, 8'h00}, 32'd0);
    @(negedge clk) clrN = 1'b1;
    repeat (4) @(negedge clk);

    // R4/R9: sweep every command code with arithmetic address and data.
    for (int c = 0; c < 16; c++) begin
      logic [3:0] a;
      logic [15:0] d;
      a = 4'(15 - c);
      d = 16'(c * 4097) ^ 16'hA5C3;
      frame({40'd0, 4'(c), a, d}, 24, "R4");
      repeat (3) @(negedge clk);
      chk("R9", "cmd holds", 32'(cmd), 32'(c));
    end

    // R5: 32-bit frame, leading 8 bits discarded.
    frame({32'd0, 8'hFF, 4'h3, 4'hF, 16'h1234}, 32, "R5");
    // R6: 40-bit frame, last 24 kept.
    frame({24'd0, 16'hBEEF, 4'h7, 4'h2, 16'h0F0F}, 40, "R6");
    // R7: 23-bit frame gives nothing.
    frame({41'd0, 23'h7FFFFF}, 23, "R7");
    // R1: serial clock toggled while deselected is ignored.
    sendBits(64'h0000_0000_0000_00A5, 8);
    frame({40'd0, 4'h5, 4'h1, 16'h8001}, 24, "R1");

    // R8: clear in mid-frame.
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
    sendBits(64'h3FF, 10);
    @(negedge clk) clrN = 1'b0;
    #1;
    chk("R8", "clear cmd", 32'(cmd), 32'd0);
    chk("R8", "clear data", 32'(data), 32'd0);
    chk("R8", "clear exec", 32'(exec), 32'd0);
    repeat (3) @(negedge clk);
    sentCnt = 0;
    eCmd = '0; eAddr = '0; eData = '0;
    clrN = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk) csN = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R8", "no exec after clear", 32'(exec), 32'd0);
    end
    frame({40'd0, 4'h9, 4'h6, 16'h00FF}, 24, "R8");

    // R10: chained pair, 64-bit frame.
    @(negedge clk) clrN = 1'b0;
    repeat (2) @(negedge clk);
    sentCnt = 0;
    clrN = 1'b1;
    repeat (3) @(negedge clk);
    frame({8'h5A, 4'hC, 4'h4, 16'hCAFE, 8'h11, 4'h2, 4'h8, 16'h7E57}, 64, "R10");
    chk("R10", "far cmd", 32'(cmd2), 32'hC);
    chk("R10", "far addr", 32'(addr2), 32'h4);
    chk("R10", "far data", 32'(data2), 32'hCAFE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule